// File: doc/BRIEF.md
# Dual Data Pointer Unit

This block keeps two 16-bit external-memory address pointers for an 8-bit microcontroller core. Each pointer is built from a low byte and a high byte. A mode register holds a select bit that picks the active pointer, and the active pointer drives the external address output at all times. The core reads and writes the pointer bytes and the mode register through a small special-function-register port. The byte registers always map onto whichever pointer is selected at that moment.

Two hardware helpers speed up block moves. The first is an explicit increment request, which completes two clock edges after it is issued. The second is a pair of optional actions on every completed external data access: the pointer that was just used can advance by one, and the select bit can flip. A copy loop can load a source into one pointer and a destination into the other, then run with nothing but a read access and a write access per byte.

Top module: `dual_dptr_unit`

## Requirements
- R1: After a synchronous active-low reset, both pointers are 0x0000, pointer 0 is selected and both automatic modes are off. The mode register reads 0x00 and `ext_addr` is 0x0000.
- R2: `reg_sel` encodes the register: 0 is the selected pointer's low byte, 1 is its high byte, 2 is the mode register, and 3 reads 0. In the mode register, bit 0 is the select bit (0 selects pointer 0, 1 selects pointer 1), bit 1 enables auto-increment and bit 2 enables auto-toggle. Bits 7:3 read as 0. A write takes effect after the clock edge on which `reg_wr` is sampled.
- R3: Reads and writes of the low and high bytes act only on the pointer selected in that cycle. The other pointer is left unchanged.
- R4: `ext_addr` equals {high, low} of the selected pointer, with no added latency.
- R5: A one-cycle `inc_req` adds 1 to the pointer selected in the request cycle. The new value appears after the second rising edge that follows the request and not after the first. The low byte carries into the high byte, and 0xFFFF wraps to 0x0000.
- R6: With auto-increment on, each `xfer_done` adds 1 to the pointer selected in that cycle. The new value appears after the next edge.
- R7: With auto-toggle on, each `xfer_done` inverts the select bit after the next edge. With both modes on, the increment goes to the pointer that was used and the selection then moves to the other pointer.
- R8: With both automatic modes off, `xfer_done` changes neither the pointers nor the select bit.
- R9: If an explicit increment completes in the same cycle as an auto-increment on the same pointer, both are applied and the pointer advances by 2.
- R10: A byte write to a pointer overrides any increment of that pointer in the same cycle: the written byte takes the data, the other byte keeps its value and the increments are dropped. A mode-register write likewise overrides an auto-toggle in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (see R2) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| inc_req | input | 1 | Explicit pointer increment request, one cycle |
| xfer_done | input | 1 | External data access completed, one cycle |
| ext_addr | output | 16 | Address from the selected pointer |

## Verification
Two functions can land on the same pointer in the same cycle. The first is the completion of an explicit increment. The second is an auto-increment from an access strobe, or a register write. The bench provokes this by issuing `inc_req` and driving `xfer_done` one cycle later. It expects the pointer to advance by exactly 2, including a carry from the low byte into the high byte. It also drives a low-byte write together with `xfer_done`, and a mode write together with an auto-toggle access, then checks that the written value survives and that the increment or toggle is lost.

// File: rtl/dptr_pkg.sv
// Shared encodings for the dual data pointer unit.
// Assumes a 2-bit register select and a 3-bit mode field.
package dptr_pkg;

    // Register select codes on the special-function-register port.
    typedef enum logic [1:0] {
        SFR_PTR_LO = 2'd0,
        SFR_PTR_HI = 2'd1,
        SFR_MODE   = 2'd2,
        SFR_NONE   = 2'd3
    } sfr_addr_e;

    // Mode register fields; bit order matches the software-visible layout.
    typedef struct packed {
        logic auto_tog;   // bit 2
        logic auto_inc;   // bit 1
        logic sel;        // bit 0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/dptr_mode_reg.sv
// Mode register: the active-pointer select bit and the two automatic-mode
// enables. A register write wins over an auto-toggle in the same cycle.
// Assumes xfer_done is a single-cycle strobe.
module dptr_mode_reg
    import dptr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [MODE_W-1:0]     wdata,
    input  logic                  xfer_done,
    output mode_t                 mode
);

    // Holds the mode fields; flips the select bit on access when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en) begin
            mode <= mode_t'(wdata);
        end else if (xfer_done && mode.auto_tog) begin
            mode.sel <= ~mode.sel;
        end
    end

    // R1: reset clears every mode field.
    a_r1_mode_clear: assert property (@(posedge clk)
        !rst_n |=> (mode == '0));

    // R7: an access with auto-toggle on and no write flips the selection.
    a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && mode.auto_tog && !wr_en) |=> (mode.sel != $past(mode.sel)));

    // R8/R10: without an access or a write the mode is left alone.
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && !wr_en) |=> $stable(mode));

endmodule

// File: rtl/dptr_inc_seq.sv
// Two-cycle sequencer for the explicit increment request. The request cycle
// records which pointer was selected; the following cycle applies the step.
// Assumes inc_req may repeat on consecutive cycles.
module dptr_inc_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_req,
    input  logic sel,
    output logic pend,
    output logic tgt
);

    // Captures the request and its target pointer for the second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            tgt  <= 1'b0;
        end else begin
            pend <= inc_req;
            tgt  <= inc_req ? sel : tgt;
        end
    end

    // R5: a request is always followed by a pending step for its pointer.
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        inc_req |=> (pend && (tgt == $past(sel))));

    // R5: no pending step appears without a request.
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_req |=> !pend);

endmodule

// File: rtl/dptr_slot.sv
// One data pointer made of a low and a high byte. A byte write replaces that
// byte and drops any step; otherwise the pointer advances by 0, 1 or 2.
// Assumes at most one of wr_lo and wr_hi is set in a cycle.
module dptr_slot #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    input  logic [1:0]          step,
    output logic [2*BYTE_W-1:0] ptr
);

    localparam int PTR_W = 2 * BYTE_W;

    // Updates the pointer from byte writes or the combined step count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_lo) begin
            ptr[BYTE_W-1:0] <= wdata;
        end else if (wr_hi) begin
            ptr[PTR_W-1:BYTE_W] <= wdata;
        end else begin
            ptr <= ptr + PTR_W'(step);
        end
    end

    // R1: reset zeroes the pointer.
    a_r1_ptr_clear: assert property (@(posedge clk)
        !rst_n |=> (ptr == '0));

    // R3: with no write and no step the pointer holds.
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && step == 2'd0) |=> $stable(ptr));

    // R6: a single step advances by one, wrapping at the top.
    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && step == 2'd1) |=> (ptr == $past(ptr) + PTR_W'(1)));

    // R9: coincident steps advance by two.
    a_r9_step_two: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi && step == 2'd2) |=> (ptr == $past(ptr) + PTR_W'(2)));

    // R10: a low-byte write wins and leaves the high byte alone.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> ((ptr[BYTE_W-1:0] == $past(wdata)) &&
                   (ptr[PTR_W-1:BYTE_W] == $past(ptr[PTR_W-1:BYTE_W]))));

endmodule

// File: rtl/dual_dptr_unit.sv
// Dual data pointer unit: two banked external-memory pointers, a mode
// register that selects the active one, a two-cycle explicit increment and
// optional auto-increment / auto-toggle on each completed external access.
// Assumes strobes are synchronous to clk and one cycle wide.
module dual_dptr_unit
    import dptr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [1:0]            reg_sel,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    input  logic                  inc_req,
    input  logic                  xfer_done,
    output logic [2*BYTE_W-1:0]   ext_addr
);

    localparam int PTR_W   = 2 * BYTE_W;
    localparam int NUM_PTR = 2;

    sfr_addr_e         addr;
    mode_t             mode;
    logic              pend;
    logic              tgt;
    logic [PTR_W-1:0]  ptrs [NUM_PTR];
    logic [PTR_W-1:0]  act_ptr;

    assign addr = sfr_addr_e'(reg_sel);

    dptr_mode_reg u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && (addr == SFR_MODE)),
        .wdata     (reg_wdata[MODE_W-1:0]),
        .xfer_done (xfer_done),
        .mode      (mode)
    );

    dptr_inc_seq u_inc (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_req (inc_req),
        .sel     (mode.sel),
        .pend    (pend),
        .tgt     (tgt)
    );

    // One pointer slot per bank, each with its own write and step decode.
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_slot
        logic       is_sel;
        logic       hit_pend;
        logic       hit_xfer;
        logic [1:0] step;

        assign is_sel   = (mode.sel == 1'(i));
        assign hit_pend = pend && (tgt == 1'(i));
        assign hit_xfer = xfer_done && mode.auto_inc && is_sel;
        assign step     = {1'b0, hit_pend} + {1'b0, hit_xfer};

        dptr_slot #(.BYTE_W(BYTE_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_lo (reg_wr && is_sel && (addr == SFR_PTR_LO)),
            .wr_hi (reg_wr && is_sel && (addr == SFR_PTR_HI)),
            .wdata (reg_wdata),
            .step  (step),
            .ptr   (ptrs[i])
        );
    end

    // Routes the selected pointer to the address output.
    always_comb begin
        act_ptr = mode.sel ? ptrs[1] : ptrs[0];
    end

    assign ext_addr = act_ptr;

    // Register read multiplexer over the selected pointer and the mode.
    always_comb begin
        unique case (addr)
            SFR_PTR_LO: reg_rdata = act_ptr[BYTE_W-1:0];
            SFR_PTR_HI: reg_rdata = act_ptr[PTR_W-1:BYTE_W];
            SFR_MODE:   reg_rdata = BYTE_W'(mode);
            default:    reg_rdata = '0;
        endcase
    end

    // R3: a byte write to the selected pointer never disturbs the other one.
    a_r3_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !mode.sel && (addr == SFR_PTR_LO || addr == SFR_PTR_HI)
         && !(pend && tgt)) |=> $stable(ptrs[1]));

endmodule

// File: tb/dual_dptr_unit_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for reset, field masking, coincident steps and write priority.
module dual_dptr_unit_bench;

    localparam logic [2:0] OP_WLO  = 3'd0;
    localparam logic [2:0] OP_WHI  = 3'd1;
    localparam logic [2:0] OP_WCTL = 3'd2;
    localparam logic [2:0] OP_INC  = 3'd3;
    localparam logic [2:0] OP_XFER = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [7:0]  data;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{OP_WLO,  8'h34, 16'h0034, 4'd3},  // R3 low byte of pointer 0
        '{OP_WHI,  8'h12, 16'h1234, 4'd3},  // R3 high byte
        '{OP_INC,  8'h00, 16'h1235, 4'd5},  // R5 plain step
        '{OP_WLO,  8'hFF, 16'h12FF, 4'd3},
        '{OP_INC,  8'h00, 16'h1300, 4'd5},  // R5 carry into high byte
        '{OP_WCTL, 8'h01, 16'h0000, 4'd4},  // R4 pointer 1 selected
        '{OP_WLO,  8'hCD, 16'h00CD, 4'd3},
        '{OP_WHI,  8'hAB, 16'hABCD, 4'd3},
        '{OP_WCTL, 8'h00, 16'h1300, 4'd3},  // R3 pointer 0 untouched
        '{OP_WCTL, 8'h03, 16'hABCD, 4'd2},  // R2 sel=1, auto-inc
        '{OP_XFER, 8'h00, 16'hABCE, 4'd6},  // R6 auto-increment
        '{OP_WCTL, 8'h06, 16'h1300, 4'd2},  // sel=0, both modes
        '{OP_XFER, 8'h00, 16'hABCE, 4'd7},  // R7 ptr0 stepped, now on ptr1
        '{OP_XFER, 8'h00, 16'h1301, 4'd7},  // R7 ptr1 stepped, back on ptr0
        '{OP_WCTL, 8'h04, 16'h1301, 4'd2},  // toggle only
        '{OP_XFER, 8'h00, 16'hABCF, 4'd7},  // R7 toggle without step
        '{OP_WCTL, 8'h00, 16'h1301, 4'd2},
        '{OP_XFER, 8'h00, 16'h1301, 4'd8},  // R8 access ignored
        '{OP_WLO,  8'hFF, 16'h13FF, 4'd3},
        '{OP_WHI,  8'hFF, 16'hFFFF, 4'd3},
        '{OP_INC,  8'h00, 16'h0000, 4'd5},  // R5 wrap to zero
        '{OP_WCTL, 8'h01, 16'hABCF, 4'd3}   // R3 pointer 1 unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [1:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic        inc_req;
    logic        xfer_done;
    logic [15:0] ext_addr;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dual_dptr_unit u_dual_dptr_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .inc_req   (inc_req),
        .xfer_done (xfer_done),
        .ext_addr  (ext_addr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 1'b0; reg_sel = 2'd0; reg_wdata = 8'h00;
        inc_req = 1'b0; xfer_done = 1'b0;
    endtask

    // Applies one operation for a cycle, idles a cycle, returns at a negedge.
    task automatic do_op(input logic [2:0] op, input logic [7:0] data);
        @(negedge clk);
        idle();
        case (op)
            OP_WLO:  begin reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = data; end
            OP_WHI:  begin reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = data; end
            OP_WCTL: begin reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = data; end
            OP_INC:  inc_req = 1'b1;
            default: xfer_done = 1'b1;
        endcase
        @(negedge clk);
        idle();
        @(negedge clk);
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [7:0] val);
        reg_sel = sel;
        #1;
        val = reg_rdata;
        reg_sel = 2'd0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        rst_n = 1'b0;
        idle();
        apply_reset();

        // R1: reset state seen at the ports.
        check("R1 addr", ext_addr, 16'h0000);
        read_reg(2'd2, rv); check("R1 mode", {8'h00, rv}, 16'h0000);
        read_reg(2'd0, rv); check("R1 low", {8'h00, rv}, 16'h0000);

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            do_op(VECS[i].op, VECS[i].data);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), ext_addr, VECS[i].exp);
        end

        // R2: reserved mode bits read 0; reg_sel 3 reads 0.
        do_op(OP_WCTL, 8'hF8);
        read_reg(2'd2, rv); check("R2 reserved bits", {8'h00, rv}, 16'h0000);
        do_op(OP_WCTL, 8'hFF);
        read_reg(2'd2, rv); check("R2 mode fields", {8'h00, rv}, 16'h0007);
        read_reg(2'd3, rv); check("R2 unused select", {8'h00, rv}, 16'h0000);
        read_reg(2'd1, rv); check("R3 high byte of ptr1", {8'h00, rv}, 16'h00AB);

        // R5: the step is not visible after the first edge, only the second.
        do_op(OP_WCTL, 8'h00);
        do_op(OP_WLO, 8'h10);
        do_op(OP_WHI, 8'h00);
        @(negedge clk); inc_req = 1'b1;
        @(negedge clk); inc_req = 1'b0;
        check("R5 not after first edge", ext_addr, 16'h0010);
        @(negedge clk);
        check("R5 after second edge", ext_addr, 16'h0011);

        // R9: explicit step completing with an auto-step on the same pointer.
        do_op(OP_WCTL, 8'h02);
        do_op(OP_WLO, 8'hFE);
        do_op(OP_WHI, 8'h10);
        @(negedge clk); inc_req = 1'b1;
        @(negedge clk); inc_req = 1'b0; xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
        check("R9 double step with carry", ext_addr, 16'h1100);

        // R10: low-byte write together with an auto-increment access.
        do_op(OP_WHI, 8'h20);
        @(negedge clk); xfer_done = 1'b1; reg_wr = 1'b1; reg_sel = 2'd0; reg_wdata = 8'h55;
        @(negedge clk); idle();
        check("R10 write beats step", ext_addr, 16'h2055);

        // R10: mode write together with an auto-toggle access.
        do_op(OP_WCTL, 8'h04);
        @(negedge clk); xfer_done = 1'b1; reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 8'h00;
        @(negedge clk); idle();
        read_reg(2'd2, rv); check("R10 mode write beats toggle", {8'h00, rv}, 16'h0000);
        check("R10 pointer 0 still active", ext_addr, 16'h2055);

        // R1: reset in mid-run clears everything.
        do_op(OP_WCTL, 8'h07);
        apply_reset();
        check("R1 addr after rerun reset", ext_addr, 16'h0000);
        read_reg(2'd2, rv); check("R1 mode after rerun reset", {8'h00, rv}, 16'h0000);
        do_op(OP_WCTL, 8'h01);
        check("R1 pointer 1 cleared", ext_addr, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule